// File: doc/BRIEF.md
# Serial transmit queue with ready and underrun flags

This block is the transmit-side flow control of one asynchronous serial channel. The CPU writes characters into an eight-slot queue. The block hands them in order to a shift stage whenever that stage is idle. The serializer reports the end of the final stop bit on `shift_done_i`. From these events the block keeps two flags for software. `tx_rdy_o` says the queue can take another character. `tx_empty_o` says the transmitter has run dry (underrun).

The block also runs the transmitter's command set: enable, disable and transmitter reset. A disable issued while characters are still queued or shifting does not stop the transmitter at once. It arms a pending stop. The queue then drains, and the transmitter turns off after the last stop bit. The underrun flag does not flash in between. While the transmitter is off, nothing is handed to the shift stage. Writes are dropped and shift-complete pulses are ignored.

Top module: `uart_tx_flow`

## Requirements
- R1: After `rst_ni` is released the transmitter is off: `tx_rdy_o`, `tx_empty_o`, `shift_busy_o` and `load_o` are all 0.
- R2: An enable command given while off raises both `tx_rdy_o` and `tx_empty_o` on the next cycle.
- R3: While the transmitter is on, `tx_rdy_o` is 1 exactly when fewer than DEPTH (8) characters are queued. It drops after the write that fills the last slot and returns after the next hand-off to the shift stage.
- R4: A write presented while `tx_rdy_o` is 0 is discarded and never reaches `load_data_o`.
- R5: Characters reach `load_data_o` in write order. Each hand-off is a one-cycle `load_o` pulse, given only when the shift stage is idle. `shift_busy_o` is 1 from the next cycle until a `shift_done_i` pulse.
- R6: `tx_empty_o` rises in the cycle after a `shift_done_i` that leaves no character queued, provided no stop is pending. It falls in the cycle after an accepted write.
- R7: A disable command in the underrun state turns the transmitter off on the next cycle: `tx_rdy_o` and `tx_empty_o` go to 0.
- R8: A disable command while characters are queued or shifting keeps `tx_rdy_o` and the hand-offs running until the queue is empty and the last `shift_done_i` arrives. The transmitter then turns off, and `tx_empty_o` stays 0 throughout.
- R9: An enable command while a stop is pending cancels the stop; the transmitter stays on.
- R10: A transmitter reset command empties the queue, clears `shift_busy_o`, cancels any pending stop and turns the transmitter off. A write in the same cycle is dropped.
- R11: Commands in the same cycle resolve as reset over disable over enable.
- R12: While off, no `load_o` is given, writes are dropped and `shift_done_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_cmd_i | input | 1 | Enable transmitter command pulse |
| dis_cmd_i | input | 1 | Disable transmitter command pulse |
| rst_cmd_i | input | 1 | Transmitter reset command pulse |
| wr_i | input | 1 | CPU write strobe |
| wr_data_i | input | W | Character written by the CPU |
| shift_done_i | input | 1 | Serializer finished the last stop bit |
| load_o | output | 1 | Character handed to the shift stage this cycle |
| load_data_o | output | W | Character being handed over, valid with `load_o` |
| shift_busy_o | output | 1 | Shift stage holds a character |
| tx_rdy_o | output | 1 | Queue has a free slot and transmitter is on |
| tx_empty_o | output | 1 | Transmitter underrun |

## Verification
The hardest state to reach is the pending stop. It needs a disable landing while both the queue and the shift stage are occupied, and it is worst when a CPU write, an enable or a reset collides with the cycle in which the drain finishes. The bench models the serializer as a busy interval whose length it sets per phase. Long intervals hold characters in the queue while commands arrive, and short ones bring the drain's end close to the next strobe. A long random phase mixes writes, commands and stray shift-complete pulses against a behavioural queue model, compared every clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    TX_OFF   = 2'd0,
    TX_ON    = 2'd1,
    TX_DRAIN = 2'd2
  } tx_mode_e;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem[wr_q] <= data_i;
  end

  assign data_o  = mem[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_cmd_i,
  input  logic     dis_cmd_i,
  input  logic     rst_cmd_i,
  input  logic     wr_i,
  input  logic     fifo_empty_i,
  input  logic     fifo_full_i,
  input  logic     shift_done_i,
  output logic     push_o,
  output logic     pop_o,
  output logic     flush_o,
  output logic     busy_o,
  output logic     rdy_o,
  output logic     empty_o,
  output tx_mode_e mode_o
);
  tx_mode_e mode_q, mode_d;
  logic     busy_q, busy_d;
  logic     idle_now;

  assign rdy_o    = (mode_q != TX_OFF) && !fifo_full_i;
  assign push_o   = wr_i && rdy_o && !rst_cmd_i;
  assign pop_o    = (mode_q != TX_OFF) && !busy_q && !fifo_empty_i && !rst_cmd_i;
  assign flush_o  = rst_cmd_i;
  // nothing queued, nothing shifting, nothing arriving this cycle
  assign idle_now = fifo_empty_i && !busy_q && !push_o;
  // a pending stop suppresses the underrun flag
  assign empty_o  = (mode_q == TX_ON) && fifo_empty_i && !busy_q;
  assign busy_o   = busy_q;
  assign mode_o   = mode_q;

  always_comb begin
    mode_d = mode_q;
    if (rst_cmd_i) begin
      mode_d = TX_OFF;
    end else if (dis_cmd_i) begin
      if (mode_q != TX_OFF) mode_d = idle_now ? TX_OFF : TX_DRAIN;
    end else if (en_cmd_i) begin
      mode_d = TX_ON;
    end else if (mode_q == TX_DRAIN && idle_now) begin
      mode_d = TX_OFF;
    end
  end

  always_comb begin
    busy_d = busy_q;
    if (rst_cmd_i)                  busy_d = 1'b0;
    else if (pop_o)                 busy_d = 1'b1;
    else if (shift_done_i && busy_q) busy_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= TX_OFF;
      busy_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_tx_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_cmd_i,
  input  logic         dis_cmd_i,
  input  logic         rst_cmd_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         shift_done_i,
  output logic         load_o,
  output logic [W-1:0] load_data_o,
  output logic         shift_busy_o,
  output logic         tx_rdy_o,
  output logic         tx_empty_o
);
  logic     push, pop, flush, fifo_empty, fifo_full;
  tx_mode_e mode;

  uart_tx_ctrl ctrl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_cmd_i     (en_cmd_i),
    .dis_cmd_i    (dis_cmd_i),
    .rst_cmd_i    (rst_cmd_i),
    .wr_i         (wr_i),
    .fifo_empty_i (fifo_empty),
    .fifo_full_i  (fifo_full),
    .shift_done_i (shift_done_i),
    .push_o       (push),
    .pop_o        (pop),
    .flush_o      (flush),
    .busy_o       (shift_busy_o),
    .rdy_o        (tx_rdy_o),
    .empty_o      (tx_empty_o),
    .mode_o       (mode)
  );

  uart_tx_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push),
    .data_i  (wr_data_i),
    .pop_i   (pop),
    .data_o  (load_data_o),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  assign load_o = pop;
endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk
  import uart_tx_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     en_cmd_i,
  input logic     dis_cmd_i,
  input logic     rst_cmd_i,
  input logic     wr_i,
  input logic     load_o,
  input logic     shift_busy_o,
  input logic     tx_rdy_o,
  input logic     tx_empty_o,
  input tx_mode_e mode
);
  // R2
  enable_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_cmd_i && !dis_cmd_i && !rst_cmd_i && mode == TX_OFF) |=> (tx_rdy_o && tx_empty_o));

  // R5
  load_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> shift_busy_o);

  // R6
  empty_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> (tx_rdy_o && !shift_busy_o && !load_o));

  // R7
  dis_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_cmd_i && tx_empty_o && !wr_i) |=> (!tx_rdy_o && !tx_empty_o));

  // R8
  drain_no_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == TX_DRAIN) |-> !tx_empty_o);

  // R10
  txrst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd_i |=> (!tx_rdy_o && !tx_empty_o && !shift_busy_o));

  // R12
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == TX_OFF) |-> (!load_o && !tx_rdy_o));
endmodule

bind uart_tx_flow uart_tx_flow_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_cmd_i     (en_cmd_i),
  .dis_cmd_i    (dis_cmd_i),
  .rst_cmd_i    (rst_cmd_i),
  .wr_i         (wr_i),
  .load_o       (load_o),
  .shift_busy_o (shift_busy_o),
  .tx_rdy_o     (tx_rdy_o),
  .tx_empty_o   (tx_empty_o),
  .mode         (mode)
);

// File: tb/uart_tx_flow_tb_top.sv
`timescale 1ns/1ps
module uart_tx_flow_tb_top;
  localparam int W     = 8;
  localparam int DEPTH = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_cmd_i = 1'b0, dis_cmd_i = 1'b0, rst_cmd_i = 1'b0;
  logic         wr_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic         shift_done_i = 1'b0;
  logic         load_o, shift_busy_o, tx_rdy_o, tx_empty_o;
  logic [W-1:0] load_data_o;

  always #2 clk_i = ~clk_i;

  uart_tx_flow #(.W(W), .DEPTH(DEPTH)) dut_i (.*);

  // behavioural reference: 0 off, 1 on, 2 stop pending
  int           mode_m = 0;
  logic [W-1:0] q_m[$];
  bit           busy_m = 0;
  int           ser_cnt = 0, ser_len = 3;
  bit           stray = 0;
  logic [W-1:0] wdat = 8'h10;
  string        cur_req = "R1";
  int           n_vec = 0, n_miss = 0;

  task automatic chk(input bit ok, input string sig, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_miss++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", cur_req, sig, act, exp, $time);
    end
  endtask

  task automatic step(input bit wr, input bit en, input bit dis, input bit rc);
    bit sd, e_rdy, e_empty, e_load, push, idle;
    @(negedge clk_i);
    sd = busy_m ? (ser_cnt >= ser_len) : stray;
    wr_i = wr; wr_data_i = wdat; en_cmd_i = en; dis_cmd_i = dis; rst_cmd_i = rc;
    shift_done_i = sd;
    #1;
    e_rdy   = (mode_m != 0) && (q_m.size() < DEPTH);
    e_empty = (mode_m == 1) && (q_m.size() == 0) && !busy_m;
    e_load  = (mode_m != 0) && !busy_m && (q_m.size() > 0) && !rc;
    chk(tx_rdy_o == e_rdy, "tx_rdy", tx_rdy_o, e_rdy);
    chk(tx_empty_o == e_empty, "tx_empty", tx_empty_o, e_empty);
    chk(shift_busy_o == busy_m, "busy", shift_busy_o, busy_m);
    chk(load_o == e_load, "load", load_o, e_load);
    if (e_load) chk(load_data_o == q_m[0], "load_data", load_data_o, q_m[0]);
    push = wr && e_rdy && !rc;
    if (rc) begin
      q_m.delete(); busy_m = 0; mode_m = 0;
    end else begin
      idle = (q_m.size() == 0) && !busy_m && !push;
      if (e_load) begin
        void'(q_m.pop_front()); busy_m = 1; ser_cnt = 0;
      end else if (busy_m && sd) busy_m = 0;
      else if (busy_m) ser_cnt++;
      if (push) q_m.push_back(wdat);
      if (dis) begin
        if (mode_m != 0) mode_m = idle ? 0 : 2;
      end else if (en) mode_m = 1;
      else if (mode_m == 2 && idle) mode_m = 0;
    end
    if (wr) wdat = wdat + 8'd1;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 400 && (busy_m || q_m.size() != 0); i++) step(0, 0, 0, 0);
    step(0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_miss++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cur_req = "R1";  idle_n(3);
    cur_req = "R12"; stray = 1; step(1, 0, 0, 0); step(1, 0, 0, 0); idle_n(3); stray = 0;
    cur_req = "R2";  step(0, 1, 0, 0); idle_n(2);
    cur_req = "R3";  ser_len = 20;
    for (int i = 0; i < 9; i++) step(1, 0, 0, 0);
    cur_req = "R4";  step(1, 0, 0, 0); step(1, 0, 0, 0);
    cur_req = "R5";  wait_quiet();
    cur_req = "R6";  ser_len = 2; step(1, 0, 0, 0); idle_n(8);
    step(1, 0, 0, 0); step(1, 0, 0, 0); wait_quiet();
    cur_req = "R7";  step(0, 0, 1, 0); idle_n(3);
    cur_req = "R8";  step(0, 1, 0, 0); ser_len = 4;
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
    step(0, 0, 1, 0); step(1, 0, 0, 0); wait_quiet(); idle_n(3);
    cur_req = "R9";  step(0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
    step(0, 0, 1, 0); idle_n(2); step(0, 1, 0, 0); wait_quiet(); idle_n(2);
    cur_req = "R10"; ser_len = 10;
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
    step(0, 0, 1, 0); idle_n(3); step(1, 0, 0, 1); idle_n(3);
    step(1, 0, 0, 0); step(0, 1, 0, 0); idle_n(2);
    cur_req = "R11"; step(0, 1, 1, 0); idle_n(2);
    step(0, 1, 0, 0); step(0, 1, 0, 1); idle_n(2);
    step(0, 1, 0, 0); ser_len = 3; step(1, 0, 0, 0); step(1, 0, 0, 0);
    step(0, 1, 1, 0); wait_quiet(); idle_n(2);
    cur_req = "R5";  step(0, 1, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 999);
      if (i % 300 == 0) ser_len = $urandom_range(0, 12);
      stray = ($urandom_range(0, 9) == 0);
      step($urandom_range(0, 1) == 1, r < 30, (r >= 30 && r < 55), (r >= 55 && r < 62));
    end
    stray = 0;
    wait_quiet();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule